// File: doc/BRIEF.md
# Debug Port Pin-Pair Acquisition Window

This block sits between two candidate two-wire pin pairs and a serial wire debug protocol engine. Each pair has a clock line and a bidirectional data line. After reset is released, the block opens a window of a fixed number of system clocks. During that window it oversamples both pairs at the system clock. On every detected rising edge of a pair's clock line, it shifts that pair's data bit into a 32-bit history. A pair wins the port when its history equals a programmed key.

Once a pair is granted, its pins are routed to the debug engine and the engine's data output is driven back onto that pair's data line. The grant lasts until the next reset. When the window closes, every pair that was not granted is reported as released to general-purpose I/O. Acquisition depends only on reset and the pins, so a port that software switched off before the reset can always be won back inside the window.

Top module: `dbg_pair_acquire`

## Requirements
- R1: While reset is held and right after its release, grant_valid_o is 0, gpio_rel_o is 00, dbg_clk_o and dbg_dat_o are 0 and wdat_oe_o is 00.
- R2: Each pair's clock and data lines pass through a two-flop synchronizer. A rising clock edge is detected two system clocks after it appears on the pin. On each detection, the synchronized data bit is shifted in least significant bit first. The pair matches when the last 32 shifted bits equal KEY, with the first bit received at bit 0.
- R3: A match counts only if its rising edge is detected at system clock edge n ≤ WIN_CYCLES, where edge 1 is the first edge after reset release. A detection at edge WIN_CYCLES+1 or later is rejected. The grant appears on the outputs after the edge that detects the match.
- R4: If both pairs match on the same clock, pair 0 is granted (grant_sel_o = 0).
- R5: At most one pair holds the grant. grant_valid_o and grant_sel_o do not change until the next reset, and any later match by either pair is ignored.
- R6: gpio_rel_o[i] is 0 during the window. From edge WIN_CYCLES onward, it is 1 for each pair i that is not granted. It is always 0 for the granted pair.
- R7: With a grant, dbg_clk_o and dbg_dat_o follow the granted pair's clock and data pins combinationally. Without a grant, both are 0.
- R8: wdat_oe_o[i] equals dbg_doe_i only for the granted pair and is 0 otherwise. wdat_o[i] equals dbg_dout_i for both pairs.
- R9: A wire clock at one third of the system clock (low for 1 clock, high for 2) is acquired correctly.
- R10: Bits received before the key do not prevent a match, because the comparison covers only the most recent 32 bits.
- R11: A sequence that differs from KEY in any bit produces no grant, and both pairs are released when the window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wclk_i | input | 2 | Clock line of each pin pair |
| wdat_i | input | 2 | Data line input of each pin pair |
| wdat_o | output | 2 | Data line output value of each pair |
| wdat_oe_o | output | 2 | Data line output enable of each pair |
| dbg_dout_i | input | 1 | Data driven by the debug engine |
| dbg_doe_i | input | 1 | Output enable from the debug engine |
| dbg_clk_o | output | 1 | Wire clock routed to the debug engine |
| dbg_dat_o | output | 1 | Wire data routed to the debug engine |
| grant_valid_o | output | 1 | A pair holds the port |
| grant_sel_o | output | 1 | Index of the granted pair |
| gpio_rel_o | output | 2 | Pair released to general-purpose I/O |

## Verification
The bench places a key's final rising edge exactly on the last in-window clock and then one clock later. An off-by-one window counter or an extra synchronizer stage would accept the late key or reject the early one. Simultaneous keys on both pairs expose a design without fixed priority, which would grant pair 1 or flip between pairs. A key sent after an earlier grant exposes a design that re-arbitrates. A key preceded by junk bits catches a comparator that demands an aligned start. A wire clock at one third of the system clock catches edge detection that loses short pulses. Release flags and output enables are compared every cycle, so a design that releases a granted pair, releases before the window closes, or drives the wrong pair's data line is reported.

// File: rtl/dbg_acq_pkg.sv
package dbg_acq_pkg;
    localparam int NPAIR = 2;
    localparam int KEY_W = 32;

    typedef struct packed {
        logic gv;
        logic sel;
    } grant_t;
endpackage

// File: rtl/dbg_acq_edge.sv
module dbg_acq_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_clk_i,
    input  logic pin_dat_i,
    output logic rise_o,
    output logic dat_o
);
    typedef struct packed {
        logic [STAGES-1:0] c;
        logic [STAGES-1:0] d;
        logic              prev;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.c    = {s_q.c[STAGES-2:0], pin_clk_i};
        s_d.d    = {s_q.d[STAGES-2:0], pin_dat_i};
        s_d.prev = s_q.c[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise_o = s_q.c[STAGES-1] & ~s_q.prev;
    assign dat_o  = s_q.d[STAGES-1];
endmodule

// File: rtl/dbg_acq_shift.sv
module dbg_acq_shift #(
    parameter int          KEY_W = 32,
    parameter logic [31:0] KEY   = 32'h0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic dat_i,
    output logic hit_o
);
    logic [KEY_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (rise_i) sh_d = {dat_i, sh_q[KEY_W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign hit_o = rise_i && (sh_d == KEY[KEY_W-1:0]);
endmodule

// File: rtl/dbg_acq_window.sv
module dbg_acq_window #(
    parameter int WIN_CYCLES = 800
) (
    input  logic clk,
    input  logic rst_n,
    output logic open_o,
    output logic closed_o
);
    localparam int CW = $clog2(WIN_CYCLES + 1);
    localparam logic [CW-1:0] LIM = CW'(WIN_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign open_o   = (cnt_q < LIM);
    assign closed_o = (cnt_q == LIM);
endmodule

// File: rtl/dbg_pair_acquire.sv
module dbg_pair_acquire
    import dbg_acq_pkg::*;
#(
    parameter int          WIN_CYCLES  = 800,
    parameter logic [31:0] KEY         = 32'h7B0C_06DB,
    parameter int          SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPAIR-1:0] wclk_i,
    input  logic [NPAIR-1:0] wdat_i,
    output logic [NPAIR-1:0] wdat_o,
    output logic [NPAIR-1:0] wdat_oe_o,
    input  logic             dbg_dout_i,
    input  logic             dbg_doe_i,
    output logic             dbg_clk_o,
    output logic             dbg_dat_o,
    output logic             grant_valid_o,
    output logic             grant_sel_o,
    output logic [NPAIR-1:0] gpio_rel_o
);
    logic [NPAIR-1:0] rise, sdat, hit;
    logic             win_open, win_closed;
    grant_t           g_d, g_q;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        dbg_acq_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_clk_i (wclk_i[p]),
            .pin_dat_i (wdat_i[p]),
            .rise_o    (rise[p]),
            .dat_o     (sdat[p])
        );
        dbg_acq_shift #(.KEY_W(KEY_W), .KEY(KEY)) u_shift (
            .clk    (clk),
            .rst_n  (rst_n),
            .rise_i (rise[p]),
            .dat_i  (sdat[p]),
            .hit_o  (hit[p])
        );
    end

    dbg_acq_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_o   (win_open),
        .closed_o (win_closed)
    );

    always_comb begin
        g_d = g_q;
        if (!g_q.gv && win_open && (hit != '0)) begin
            g_d.gv  = 1'b1;
            g_d.sel = ~hit[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    always_comb begin
        for (int p = 0; p < NPAIR; p++) begin
            gpio_rel_o[p] = win_closed && !(g_q.gv && (g_q.sel == p[0]));
            wdat_oe_o[p]  = g_q.gv && (g_q.sel == p[0]) && dbg_doe_i;
            wdat_o[p]     = dbg_dout_i;
        end
    end

    assign grant_valid_o = g_q.gv;
    assign grant_sel_o   = g_q.sel;
    assign dbg_clk_o     = g_q.gv && wclk_i[g_q.sel];
    assign dbg_dat_o     = g_q.gv && wdat_i[g_q.sel];
endmodule

// File: rtl/dbg_acq_chk.sv
module dbg_acq_chk #(
    parameter int WIN_CYCLES = 800
) (
    input logic       clk,
    input logic       rst_n,
    input logic       gv,
    input logic       sel,
    input logic [1:0] rel,
    input logic [1:0] oe,
    input logic       dclk
);
    int unsigned cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cyc_q <= 0;
        else if (cyc_q <= WIN_CYCLES) cyc_q <= cyc_q + 1;
    end

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n) gv |=> (gv && $stable(sel))); // R5
    AST_GRANT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(gv) |-> (cyc_q <= WIN_CYCLES)); // R3
    AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (cyc_q < WIN_CYCLES) |-> (rel == 2'b00)); // R6
    AST_GRANTED_KEPT: assert property (@(posedge clk) disable iff (!rst_n) gv |-> !rel[sel]); // R6
    AST_OE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n) !gv |-> (oe == 2'b00)); // R8
    AST_OE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(oe)); // R5
    AST_CLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !gv |-> !dclk); // R7
endmodule

bind dbg_pair_acquire dbg_acq_chk #(.WIN_CYCLES(WIN_CYCLES)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .gv   (grant_valid_o),
    .sel  (grant_sel_o),
    .rel  (gpio_rel_o),
    .oe   (wdat_oe_o),
    .dclk (dbg_clk_o)
);

// File: tb/sim_dbg_pair_acquire.sv
module sim_dbg_pair_acquire;
    localparam int          CLK_PER = 10;
    localparam int          WIN     = 300;
    localparam logic [31:0] KEY     = 32'hA5C3_96E1;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [1:0] pc = '0, pd = '0;
    logic       dout = 1'b0, doe = 1'b0;
    logic [1:0] wdat_o, wdat_oe_o, gpio_rel_o;
    logic       dbg_clk_o, dbg_dat_o, grant_valid_o, grant_sel_o;

    int checks = 0, errors = 0;
    bit done = 0;

    dbg_pair_acquire #(.WIN_CYCLES(WIN), .KEY(KEY), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .wclk_i(pc), .wdat_i(pd),
        .wdat_o(wdat_o), .wdat_oe_o(wdat_oe_o),
        .dbg_dout_i(dout), .dbg_doe_i(doe),
        .dbg_clk_o(dbg_clk_o), .dbg_dat_o(dbg_dat_o),
        .grant_valid_o(grant_valid_o), .grant_sel_o(grant_sel_o),
        .gpio_rel_o(gpio_rel_o)
    );

    always #(CLK_PER/2) clk = ~clk;

    // reference model: pin history, received bits, grant
    logic [2:0]  hc [2];
    logic [2:0]  hd [2];
    logic [31:0] msh [2];
    logic        mgv, msel;
    int          ecount;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin hc[i] = '0; hd[i] = '0; msh[i] = '0; end
            mgv = 1'b0; msel = 1'b0; ecount = 0;
        end else begin
            logic [1:0] mh;
            int n;
            n = ecount + 1;
            for (int i = 0; i < 2; i++) begin
                mh[i] = 1'b0;
                if (hc[i][1] && !hc[i][2]) begin
                    msh[i] = {hd[i][1], msh[i][31:1]};
                    mh[i]  = (msh[i] == KEY) && (n <= WIN);
                end
            end
            if (!mgv && mh != 2'b00) begin
                mgv  = 1'b1;
                msel = !mh[0];
            end
            for (int i = 0; i < 2; i++) begin
                hc[i] = {hc[i][1:0], pc[i]};
                hd[i] = {hd[i][1:0], pd[i]};
            end
            ecount = n;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [1:0] erel, eoe;
            for (int i = 0; i < 2; i++) begin
                erel[i] = (ecount >= WIN) && !(mgv && msel == i[0]);
                eoe[i]  = mgv && (msel == i[0]) && doe;
            end
            chk("R3 R5 grant_valid", grant_valid_o, mgv);
            if (mgv) chk("R4 grant_sel", grant_sel_o, msel);
            chk("R6 gpio_rel", gpio_rel_o, erel);
            chk("R7 dbg_clk", dbg_clk_o, mgv ? pc[msel] : 1'b0);
            chk("R7 dbg_dat", dbg_dat_o, mgv ? pd[msel] : 1'b0);
            chk("R8 wdat_oe", wdat_oe_o, eoe);
            chk("R8 wdat", wdat_o, {dout, dout});
        end
    end

    task automatic cyc(int k);
        repeat (k) @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); #1;
        rst_n = 1'b0; pc = '0; pd = '0; doe = 1'b0; dout = 1'b0;
        cyc(1);
        chk("R1 reset grant", grant_valid_o, 0);
        chk("R1 reset rel", gpio_rel_o, 0);
        chk("R1 reset oe", wdat_oe_o, 0);
        chk("R1 reset dclk", dbg_clk_o, 0);
        cyc(2);
        rst_n = 1'b1;
    endtask

    task automatic send_bit(int p, logic b, int lo, int hi);
        pd[p] = b; pc[p] = 1'b0;
        cyc(lo);
        pc[p] = 1'b1;
        cyc(hi);
    endtask

    task automatic send_word(int p, logic [31:0] w, int lo, int hi);
        for (int i = 0; i < 32; i++) send_bit(p, w[i], lo, hi);
        pc[p] = 1'b0;
    endtask

    task automatic wait_until(int e);
        while (ecount < e) cyc(1);
    endtask

    task automatic finish_window();
        wait_until(WIN + 4);
    endtask

    initial begin
        #(CLK_PER * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset, then pair 0 key early (R2)
        do_reset();
        chk("R1 after release", grant_valid_o, 0);
        cyc(5);
        send_word(0, KEY, 2, 2);
        cyc(4);
        chk("R2 pair0 grant", grant_valid_o, 1);
        chk("R2 pair0 sel", grant_sel_o, 0);
        chk("R6 no release in window", gpio_rel_o, 2'b00);
        // R7/R8 routing
        doe = 1'b1; dout = 1'b1; pc[0] = 1'b1; pd[0] = 1'b1; pc[1] = 1'b0;
        cyc(1);
        chk("R8 oe to pair0", wdat_oe_o, 2'b01);
        chk("R8 data out", wdat_o, 2'b11);
        chk("R7 clk routed", dbg_clk_o, 1);
        chk("R7 dat routed", dbg_dat_o, 1);
        pc[0] = 1'b0; doe = 1'b0;
        cyc(1);
        chk("R7 clk follows", dbg_clk_o, 0);
        finish_window();
        chk("R6 pair1 released", gpio_rel_o, 2'b10);

        // pair 1 at one third rate (R9), then pair 0 key ignored (R5)
        do_reset();
        send_word(1, KEY, 1, 2);
        cyc(4);
        chk("R9 fast clock grant", grant_valid_o, 1);
        chk("R9 fast clock sel", grant_sel_o, 1);
        send_word(0, KEY, 2, 2);
        cyc(4);
        chk("R5 later match ignored", grant_sel_o, 1);
        doe = 1'b1;
        cyc(1);
        chk("R8 oe to pair1", wdat_oe_o, 2'b10);
        doe = 1'b0;
        finish_window();
        chk("R6 pair0 released", gpio_rel_o, 2'b01);

        // both at once (R4)
        do_reset();
        fork
            send_word(0, KEY, 2, 2);
            send_word(1, KEY, 2, 2);
        join
        cyc(4);
        chk("R4 priority grant", grant_valid_o, 1);
        chk("R4 priority sel", grant_sel_o, 0);
        finish_window();

        // wrong key (R11)
        do_reset();
        send_word(0, KEY ^ 32'h0000_0100, 2, 2);
        finish_window();
        chk("R11 wrong key no grant", grant_valid_o, 0);
        chk("R11 both released", gpio_rel_o, 2'b11);

        // junk prefix (R10)
        do_reset();
        send_word(1, 32'h1234_5F0E, 1, 2);
        send_word(1, KEY, 1, 2);
        cyc(4);
        chk("R10 prefix grant", grant_valid_o, 1);
        chk("R10 prefix sel", grant_sel_o, 1);
        finish_window();

        // last in-window edge (R3)
        do_reset();
        wait_until(WIN - 129);
        send_word(0, KEY, 2, 2);
        finish_window();
        chk("R3 last edge accepted", grant_valid_o, 1);

        // one edge late (R3)
        do_reset();
        wait_until(WIN - 128);
        send_word(0, KEY, 2, 2);
        finish_window();
        chk("R3 late edge rejected", grant_valid_o, 0);
        chk("R3 late both released", gpio_rel_o, 2'b11);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule